// File: doc/BRIEF.md
# Bus-Stealing Block Transfer Engine

This block copies a run of words between a peripheral data port and system memory without the processor handling each word. Software loads a start address, a word count and a transfer direction through a small register port, then writes a start bit. The engine waits for the peripheral to signal that it is ready. It then requests the shared memory bus from the processor and waits for a grant. While it owns the bus it moves one word in each granted cycle. After each word it advances the address and reduces the remaining count. When the count is used up it releases the bus and raises a sticky interrupt that software clears.

The controller is built around five named states. IDLE waits for a start write. ARMED waits for the device request. WAIT_GNT holds the bus request until the processor grants. MOVE performs one access per granted cycle. COMPLETE lasts one cycle and then returns to IDLE. The transitions are as follows. Start with a nonzero count goes IDLE->ARMED. Start with a zero count goes IDLE->COMPLETE. A device request goes ARMED->WAIT_GNT. A grant goes WAIT_GNT->MOVE. The access that moves the last word goes MOVE->COMPLETE. COMPLETE->IDLE happens unconditionally.

Top module: `dma_xfer_ctrl`

## Requirements
- R1: After reset, bus_req, irq, mem_we, mem_re, dev_ack and dev_wvalid are all low.
- R2: A write to register select 2 with bit 1 set starts a transfer when the engine is idle. Bit 0 of the same write gives the direction (0 = device to memory, 1 = memory to device). With a nonzero count, bus_req stays low until dev_req is seen.
- R3: bus_req rises in the cycle after dev_req is sampled while armed. mem_we and mem_re are only ever high while both bus_req and bus_gnt are high.
- R4: In device-to-memory mode, each granted cycle in MOVE drives mem_we with mem_wdata equal to dev_rdata and pulses dev_ack. The first address is the value last written to select 0. Each later address is one higher, wrapping modulo 2^ADDR_W.
- R5: In memory-to-device mode, each granted cycle drives mem_re at the current address. The word returned on mem_rdata appears on dev_wdata with dev_wvalid high in the following cycle.
- R6: While bus_req is high and bus_gnt is low, no access happens and mem_addr holds. The transfer resumes at the same address once the grant returns.
- R7: Exactly the programmed number of words (select 1) is moved. bus_req drops in the cycle after the final access.
- R8: irq rises in the same cycle that bus_req drops. It stays high until a write to select 3 with bit 0 set.
- R9: A start with a word count of zero sets irq in the cycle after the start write and never raises bus_req.
- R10: Writes to selects 0, 1 and 2 while a transfer is under way are ignored. The running transfer keeps its addresses, and the stored start address is unchanged for later transfers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 address, 1 count, 2 control, 3 interrupt clear |
| reg_wdata | input | DATA_W | Register write data |
| dev_req | input | 1 | Peripheral ready to transfer |
| dev_rdata | input | DATA_W | Word offered by the peripheral |
| dev_ack | output | 1 | Peripheral word consumed this cycle |
| dev_wdata | output | DATA_W | Word delivered to the peripheral |
| dev_wvalid | output | 1 | dev_wdata valid this cycle |
| bus_req | output | 1 | Request for the shared memory bus |
| bus_gnt | input | 1 | Bus granted by the processor |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| mem_rdata | input | DATA_W | Memory read data, valid in the cycle of mem_re |
| irq | output | 1 | Sticky completion interrupt |

## Verification
The bench builds the engine with an 8-bit address, 16-bit data and a 4-bit counter. With these widths, a start address of 0xFE wraps past the top of memory within a few words, and the largest count of 15 stays short. The bench holds the grant back for a programmable latency and withdraws it mid-block to exercise stalls. It pokes the registers during a transfer to show the writes are ignored. The zero-count path is also covered.

// File: rtl/dma_pkg.sv
package dma_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARMED,
        ST_WAIT_GNT,
        ST_MOVE,
        ST_COMPLETE
    } dma_state_t;

    typedef enum logic {
        DIR_DEV2MEM = 1'b0,
        DIR_MEM2DEV = 1'b1
    } dma_dir_t;

    localparam logic [1:0] SEL_BASE  = 2'd0;
    localparam logic [1:0] SEL_COUNT = 2'd1;
    localparam logic [1:0] SEL_CTRL  = 2'd2;
    localparam logic [1:0] SEL_CLEAR = 2'd3;

    localparam int CTRL_DIR_BIT   = 0;
    localparam int CTRL_START_BIT = 1;
    localparam int CLEAR_IRQ_BIT  = 0;

endpackage

// File: rtl/dma_cfg_regs.sv
module dma_cfg_regs
    import dma_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [1:0]        reg_sel,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              idle,
    input  logic              irq_set,
    output logic [ADDR_W-1:0] base_addr,
    output logic [CNT_W-1:0]  word_cnt,
    output dma_dir_t          dir,
    output logic              start,
    output logic              cnt_is_zero,
    output logic              irq
);

    logic wr_base, wr_count, wr_ctrl, wr_clear;

    always_comb begin
        wr_base  = reg_wr && (reg_sel == SEL_BASE)  && idle;
        wr_count = reg_wr && (reg_sel == SEL_COUNT) && idle;
        wr_ctrl  = reg_wr && (reg_sel == SEL_CTRL)  && idle;
        wr_clear = reg_wr && (reg_sel == SEL_CLEAR) && reg_wdata[CLEAR_IRQ_BIT];
        start       = wr_ctrl && reg_wdata[CTRL_START_BIT];
        cnt_is_zero = (word_cnt == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_addr <= '0;
            word_cnt  <= '0;
            dir       <= DIR_DEV2MEM;
        end else begin
            if (wr_base)  base_addr <= reg_wdata[ADDR_W-1:0];
            if (wr_count) word_cnt  <= reg_wdata[CNT_W-1:0];
            if (wr_ctrl)  dir       <= dma_dir_t'(reg_wdata[CTRL_DIR_BIT]);
        end
    end

    // completion wins over a clear arriving in the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        irq <= 1'b0;
        else if (irq_set)  irq <= 1'b1;
        else if (wr_clear) irq <= 1'b0;
    end

endmodule

// File: rtl/dma_fsm.sv
module dma_fsm
    import dma_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       cnt_is_zero,
    input  logic       dev_req,
    input  logic       bus_gnt,
    input  logic       last_word,
    output dma_state_t state,
    output logic       bus_req,
    output logic       access,
    output logic       irq_set,
    output logic       idle
);

    dma_state_t state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_d;
    end

    always_comb begin
        state_d = state;
        unique case (state)
            ST_IDLE:     if (start) state_d = cnt_is_zero ? ST_COMPLETE : ST_ARMED;
            ST_ARMED:    if (dev_req) state_d = ST_WAIT_GNT;
            ST_WAIT_GNT: if (bus_gnt) state_d = ST_MOVE;
            ST_MOVE:     if (bus_gnt && last_word) state_d = ST_COMPLETE;
            ST_COMPLETE: state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        bus_req = 1'b0;
        access  = 1'b0;
        idle    = 1'b0;
        unique case (state)
            ST_IDLE:     idle = 1'b1;
            ST_ARMED:    ;
            ST_WAIT_GNT: bus_req = 1'b1;
            ST_MOVE: begin
                bus_req = 1'b1;
                access  = bus_gnt;
            end
            ST_COMPLETE: ;
            default:     ;
        endcase
        irq_set = (state_d == ST_COMPLETE) && (state != ST_COMPLETE);
    end

endmodule

// File: rtl/dma_datapath.sv
module dma_datapath
    import dma_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [CNT_W-1:0]  word_cnt,
    input  dma_dir_t          dir,
    input  logic              access,
    input  logic [DATA_W-1:0] dev_rdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_we,
    output logic              mem_re,
    output logic              dev_ack,
    output logic [DATA_W-1:0] dev_wdata,
    output logic              dev_wvalid,
    output logic              last_word
);

    localparam logic [CNT_W-1:0]  CNT_ONE  = CNT_W'(1);
    localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);

    logic [ADDR_W-1:0] cur_addr;
    logic [CNT_W-1:0]  cur_cnt;
    logic [DATA_W-1:0] fwd_data;
    logic              fwd_valid;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_addr <= '0;
            cur_cnt  <= '0;
        end else if (load) begin
            cur_addr <= base_addr;
            cur_cnt  <= word_cnt;
        end else if (access) begin
            cur_addr <= cur_addr + ADDR_ONE;
            cur_cnt  <= cur_cnt - CNT_ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fwd_data  <= '0;
            fwd_valid <= 1'b0;
        end else begin
            fwd_valid <= access && (dir == DIR_MEM2DEV);
            if (access && (dir == DIR_MEM2DEV)) fwd_data <= mem_rdata;
        end
    end

    always_comb begin
        mem_addr   = cur_addr;
        mem_wdata  = dev_rdata;
        mem_we     = access && (dir == DIR_DEV2MEM);
        mem_re     = access && (dir == DIR_MEM2DEV);
        dev_ack    = mem_we;
        dev_wdata  = fwd_data;
        dev_wvalid = fwd_valid;
        last_word  = (cur_cnt == CNT_ONE);
    end

endmodule

// File: rtl/dma_xfer_ctrl.sv
module dma_xfer_ctrl
    import dma_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [1:0]        reg_sel,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              dev_req,
    input  logic [DATA_W-1:0] dev_rdata,
    output logic              dev_ack,
    output logic [DATA_W-1:0] dev_wdata,
    output logic              dev_wvalid,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_we,
    output logic              mem_re,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              irq
);

    logic [ADDR_W-1:0] base_addr;
    logic [CNT_W-1:0]  word_cnt;
    dma_dir_t          dir;
    dma_state_t        state;
    logic start, cnt_is_zero, idle, irq_set, access, last_word;

    dma_cfg_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .idle(idle), .irq_set(irq_set),
        .base_addr(base_addr), .word_cnt(word_cnt), .dir(dir),
        .start(start), .cnt_is_zero(cnt_is_zero), .irq(irq)
    );

    dma_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .start(start), .cnt_is_zero(cnt_is_zero),
        .dev_req(dev_req), .bus_gnt(bus_gnt), .last_word(last_word),
        .state(state), .bus_req(bus_req), .access(access),
        .irq_set(irq_set), .idle(idle)
    );

    dma_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_dp (
        .clk(clk), .rst_n(rst_n), .load(start), .base_addr(base_addr),
        .word_cnt(word_cnt), .dir(dir), .access(access),
        .dev_rdata(dev_rdata), .mem_rdata(mem_rdata), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_re(mem_re),
        .dev_ack(dev_ack), .dev_wdata(dev_wdata), .dev_wvalid(dev_wvalid),
        .last_word(last_word)
    );

endmodule

// File: rtl/dma_xfer_ctrl_chk.sv
module dma_xfer_ctrl_chk #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [1:0]        reg_sel,
    input logic [DATA_W-1:0] reg_wdata,
    input logic              bus_req,
    input logic              bus_gnt,
    input logic              mem_we,
    input logic              mem_re,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              dev_ack,
    input logic              dev_wvalid,
    input logic              irq
);

    logic [CNT_W-1:0] unused_cnt;
    assign unused_cnt = '0;

    assert_access_owns_bus_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we || mem_re) |-> (bus_req && bus_gnt));

    assert_single_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re));

    assert_write_acks_device_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> dev_ack);

    assert_read_forwards_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re |=> dev_wvalid);

    assert_forward_needs_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        dev_wvalid |-> $past(mem_re));

    assert_addr_holds_in_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && $past(bus_req) && !$past(mem_we || mem_re)) |-> $stable(mem_addr));

    assert_release_after_access_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_req) |-> $past(mem_we || mem_re));

    assert_irq_at_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_req) |-> irq);

    assert_irq_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !(reg_wr && reg_sel == 2'd3 && reg_wdata[0])) |=> irq);

endmodule

bind dma_xfer_ctrl dma_xfer_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .mem_we(mem_we), .mem_re(mem_re),
    .mem_addr(mem_addr), .dev_ack(dev_ack), .dev_wvalid(dev_wvalid), .irq(irq)
);

// File: tb/tb_dma_xfer_ctrl.sv
`timescale 1ns/1ps
module tb_dma_xfer_ctrl;

    localparam int AW = 8;
    localparam int DW = 16;
    localparam int CW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic [1:0]    reg_sel = 2'd0;
    logic [DW-1:0] reg_wdata = '0;
    logic          dev_req = 1'b0;
    logic [DW-1:0] dev_rdata;
    logic          dev_ack;
    logic [DW-1:0] dev_wdata;
    logic          dev_wvalid;
    logic          bus_req;
    logic          bus_gnt = 1'b0;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic          mem_we;
    logic          mem_re;
    logic [DW-1:0] mem_rdata;
    logic          irq;

    dma_xfer_ctrl #(.ADDR_W(AW), .DATA_W(DW), .CNT_W(CW)) dut (.*);

    always #4 clk = ~clk;   // 125 MHz

    int total = 0;
    int fails = 0;
    int cyc = 0;
    int dev_idx = 0;
    int gnt_lat = 1;
    int gcnt = 0;
    bit gnt_block = 1'b0;
    int acc_last = -1;
    int breq_last = -1;
    int irq_rise = -1;
    bit irq_prev = 1'b0;
    bit finished = 1'b0;

    logic [DW-1:0] mem_model [0:(1<<AW)-1];
    logic [AW-1:0] addr_q [$];
    logic [DW-1:0] data_q [$];

    function automatic logic [DW-1:0] pat(int i);
        return DW'(16'hA500 + i * 7);
    endfunction

    assign dev_rdata = pat(dev_idx);
    assign mem_rdata = mem_model[mem_addr];

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // processor side: grant after a latency, withdrawable
    always @(posedge clk) begin
        #1;
        if (!rst_n || !bus_req) begin
            gcnt = 0;
            bus_gnt = 1'b0;
        end else begin
            gcnt++;
            bus_gnt = !gnt_block && (gcnt >= gnt_lat);
        end
    end

    // monitor: pops expected items and compares
    always @(negedge clk) begin
        if (rst_n) begin
            cyc++;
            if (bus_req) breq_last = cyc;
            if (irq && !irq_prev) irq_rise = cyc;
            irq_prev = irq;
            if (mem_we || mem_re) begin
                acc_last = cyc;
                chk(bus_gnt && bus_req, "R3", "access without owned bus", bus_gnt, 1);
                if (addr_q.size() == 0) chk(0, "R7", "extra access", mem_addr, 0);
                else begin
                    logic [AW-1:0] ea;
                    ea = addr_q.pop_front();
                    chk(mem_addr == ea, "R4", "address", mem_addr, ea);
                end
            end
            if (mem_we) begin
                chk(dev_ack, "R4", "dev_ack with write", dev_ack, 1);
                if (data_q.size() == 0) chk(0, "R7", "extra write", mem_wdata, 0);
                else begin
                    logic [DW-1:0] ed;
                    ed = data_q.pop_front();
                    chk(mem_wdata == ed, "R4", "write data", mem_wdata, ed);
                end
                mem_model[mem_addr] = mem_wdata;
                dev_idx++;
            end
            if (dev_wvalid) begin
                if (data_q.size() == 0) chk(0, "R5", "extra device word", dev_wdata, 0);
                else begin
                    logic [DW-1:0] ed;
                    ed = data_q.pop_front();
                    chk(dev_wdata == ed, "R5", "device word", dev_wdata, ed);
                end
            end
        end
    end

    task automatic reg_write(input logic [1:0] sel, input logic [DW-1:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    // driver: programs a transfer and pushes the expected items
    task automatic run_xfer(input bit m2d, input logic [AW-1:0] base, input int n,
                            input int lat, input bit wr_base, input int stall_at,
                            input bit poke);
        int k;
        gnt_lat = lat;
        if (wr_base) reg_write(2'd0, DW'(base));
        reg_write(2'd1, DW'(n));
        for (int i = 0; i < n; i++) begin
            logic [AW-1:0] a;
            a = base + AW'(i);
            addr_q.push_back(a);
            data_q.push_back(m2d ? mem_model[a] : pat(dev_idx + i));
        end
        reg_write(2'd2, {14'd0, 1'b1, m2d});
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(bus_req == 1'b0, "R2", "bus_req before dev_req", bus_req, 0);
        end
        dev_req = 1'b1;
        @(negedge clk);
        dev_req = 1'b0;
        chk(bus_req == 1'b1, "R3", "bus_req after dev_req", bus_req, 1);
        k = 0;
        while (!irq && k < 200) begin
            if (poke && k == 1) begin
                reg_write(2'd0, 16'h0077);
                reg_write(2'd2, 16'h0003);
            end
            if (k == stall_at) gnt_block = 1'b1;
            if (k == stall_at + 3) gnt_block = 1'b0;
            @(negedge clk);
            k++;
        end
        gnt_block = 1'b0;
        @(negedge clk);
        chk(addr_q.size() == 0 && data_q.size() == 0, "R7", "words left over",
            addr_q.size() + data_q.size(), 0);
        chk(breq_last == acc_last, "R7", "last bus_req cycle", breq_last, acc_last);
        chk(irq_rise == acc_last + 1, "R8", "irq rise cycle", irq_rise, acc_last + 1);
        repeat (3) @(negedge clk);
        chk(irq == 1'b1, "R8", "irq sticky", irq, 1);
        reg_write(2'd3, 16'h0001);
        chk(irq == 1'b0, "R8", "irq cleared", irq, 0);
    endtask

    initial begin
        for (int i = 0; i < (1 << AW); i++) mem_model[i] = DW'(16'h3C00 ^ (i * 5));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!bus_req && !irq, "R1", "bus_req/irq after reset", {bus_req, irq}, 0);
        chk(!mem_we && !mem_re, "R1", "memory strobes after reset", {mem_we, mem_re}, 0);
        chk(!dev_ack && !dev_wvalid, "R1", "device strobes after reset", {dev_ack, dev_wvalid}, 0);

        // R4: device to memory, plain
        run_xfer(1'b0, 8'h10, 5, 1, 1'b1, -1, 1'b0);
        // R5: memory to device with a slow grant
        run_xfer(1'b1, 8'h40, 6, 3, 1'b1, -1, 1'b0);
        // R4: address wrap at the top of memory
        run_xfer(1'b0, 8'hFE, 4, 1, 1'b1, -1, 1'b0);
        // R6: grant withdrawn mid-block
        run_xfer(1'b0, 8'h80, 8, 1, 1'b1, 3, 1'b0);
        run_xfer(1'b1, 8'h90, 7, 2, 1'b1, 2, 1'b0);
        // R10: register pokes during a transfer are ignored
        run_xfer(1'b0, 8'h20, 12, 1, 1'b1, -1, 1'b1);
        // R10: stored start address survived the pokes
        run_xfer(1'b1, 8'h20, 3, 1, 1'b0, -1, 1'b0);
        // R7: largest count the counter holds
        run_xfer(1'b0, 8'hC0, 15, 1, 1'b1, -1, 1'b0);

        // R9: zero count
        begin
            int bl;
            bl = breq_last;
            reg_write(2'd1, 16'd0);
            reg_write(2'd2, 16'h0002);
            chk(irq == 1'b1, "R9", "irq after zero-count start", irq, 1);
            for (int i = 0; i < 4; i++) begin
                @(negedge clk);
                chk(bus_req == 1'b0, "R9", "bus_req on zero count", bus_req, 0);
            end
            chk(breq_last == bl, "R9", "bus requested", breq_last, bl);
            reg_write(2'd3, 16'h0001);
            chk(irq == 1'b0, "R9", "irq cleared", irq, 0);
        end

        finished = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!finished) begin
            total++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

endmodule